// File: doc/BRIEF.md
# Eight-bit GPIO port with edge interrupts

This block is an eight-pin general-purpose I/O port with a register interface. Software sets each pin's drive value and direction. It reads back the synchronized pin levels. It chooses, per pin, which input transition raises an interrupt flag. Every pin can be an input, an output and an interrupt source at the same time.

The interrupt state is split across two register spaces. Pins 0 and 1 keep their flag and enable bits in a special-function register pair. Pins 2 to 7 keep theirs in a pair of narrower port registers. Three request lines leave the block: one for pin 0, one for pin 1, and one shared by pins 2 to 7. Pins 1 and 2 can take their output value from an external timer through a select input. The timer itself lies outside the block.

The register map uses a 3-bit word address:
- 0: pin levels, read only
- 1: output value
- 2: direction
- 3: edge select
- 4: port flags
- 5: port enables
- 6: special flags
- 7: special enables

Writes to address 0 are ignored.

Top module: `gpio8_irq_port`

## Requirements
- R1: After reset, the direction, output and edge-select registers are 0. All flag and enable bits are 0, and all three request outputs are low.
- R2: `pad_oe[i]` equals direction bit i, where 1 means drive. `pad_out[i]` equals output bit i unless an alternate select overrides that pin (see R9).
- R3: Address 0 returns the pin levels through a two-flop synchronizer. A change on `pad_in` before clock edge k reads back after edge k+1 and not after edge k.
- R4: Edge-select bit 0 makes a pin's flag set on a rising synchronized input. Bit 1 makes it set on a falling one. The flag is visible after the third clock edge that follows the pad change, and the opposite transition leaves it clear.
- R5: A flag sets on its selected edge whether or not its enable bit is set.
- R6: A write to a flag register stores the written bits: 0 clears a flag and 1 sets it. If a hardware set lands in the same cycle as a clearing write, the flag ends up set.
- R7: Pins 0 and 1 keep their flag and enable in bits 0 and 1 of addresses 6 and 7, whose bits 7:2 read 0. Pins 2 to 7 use bits 7:2 of addresses 4 and 5, whose bits 1:0 read 0 and ignore writes.
- R8: `irq_pin0` is flag0 AND enable0. `irq_pin1` is flag1 AND enable1. `irq_shared` is the OR of flag AND enable over pins 2 to 7.
- R9: `alt_sel[0]` set makes `pad_out[1]` follow `alt_out[0]`. `alt_sel[1]` set makes `pad_out[2]` follow `alt_out[1]`. Direction is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| pad_in | input | 8 | Pin input levels |
| pad_out | output | 8 | Pin output values |
| pad_oe | output | 8 | Pin output enables |
| alt_sel | input | 2 | Timer takeover of pins 1 and 2 |
| alt_out | input | 2 | Timer output values for pins 1 and 2 |
| irq_pin0 | output | 1 | Request for pin 0 |
| irq_pin1 | output | 1 | Request for pin 1 |
| irq_shared | output | 1 | Request shared by pins 2 to 7 |

## Verification
The bench sweeps every pin under both edge polarities and both transition directions.
- A design that inverted the polarity, or swapped which register holds a pin's flag, would flag the wrong transition or show the bit at the wrong address.
- It forces a hardware set into the same cycle as a clearing write. A design that let software win would lose an interrupt there.
- Each pin's request is routed to its own output with enables masked and unmasked. This catches a pin wired into the wrong request group.
- The synchronizer latency is probed one edge early and on time. This exposes a missing or extra flop.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int PINS   = 8;
  localparam int AW     = 3;
  localparam int NSPEC  = 2;            // pins held in the special-function space
  localparam int NPORT  = PINS - NSPEC; // pins held in the port flag/enable space

  typedef enum logic [AW-1:0] {
    A_LEVEL = 3'd0,
    A_OUT   = 3'd1,
    A_DIR   = 3'd2,
    A_EDGE  = 3'd3,
    A_PFLAG = 3'd4,
    A_PEN   = 3'd5,
    A_SFLAG = 3'd6,
    A_SEN   = 3'd7
  } reg_addr_t;

  // select 0 = rising, 1 = falling
  function automatic logic edge_hit(input logic now_v, input logic was_v, input logic sel);
    return sel ? (was_v & ~now_v) : (now_v & ~was_v);
  endfunction
endpackage

// File: rtl/gpio_sync_edge.sv
module gpio_sync_edge #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  input  logic [W-1:0] sel_i,
  output logic [W-1:0] level_o,
  output logic [W-1:0] event_o
);
  import gpio_pkg::*;

  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign level_o = sync_q;

  for (genvar i = 0; i < W; i++) begin : g_det
    assign event_o[i] = edge_hit(sync_q[i], prev_q[i], sel_i[i]);

    // R4: an event only on a real change of the synchronized level
    a_r4_event_on_change: assert property (@(posedge clk) disable iff (!rst_n)
      event_o[i] |-> (sync_q[i] != prev_q[i]));
  end
endmodule

// File: rtl/gpio_flag_reg.sv
module gpio_flag_reg #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] set_i,
  output logic [W-1:0] flag_o
);
  logic [W-1:0] flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    flag_q <= '0;
    else if (wr_i) flag_q <= wdata_i | set_i;
    else           flag_q <= flag_q | set_i;
  end

  assign flag_o = flag_q;

  for (genvar i = 0; i < W; i++) begin : g_chk
    // R6: a hardware set is never lost, even under a clearing write
    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> flag_o[i]);
    // R5/R6: without a set or a write a clear flag stays clear
    a_r6_hold_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_o[i] && !set_i[i] && !wr_i) |=> !flag_o[i]);
  end
endmodule

// File: rtl/gpio8_irq_port.sv
module gpio8_irq_port (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] bus_addr,
  input  logic       bus_we,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic [7:0] pad_in,
  output logic [7:0] pad_out,
  output logic [7:0] pad_oe,
  input  logic [1:0] alt_sel,
  input  logic [1:0] alt_out,
  output logic       irq_pin0,
  output logic       irq_pin1,
  output logic       irq_shared
);
  import gpio_pkg::*;

  logic [PINS-1:0]  out_q, dir_q, edge_q;
  logic [NSPEC-1:0] sen_q;
  logic [NPORT-1:0] pen_q;
  logic [PINS-1:0]  level, event_w;
  logic [NSPEC-1:0] sflag;
  logic [NPORT-1:0] pflag;
  logic             wr_sflag, wr_pflag;

  assign wr_sflag = bus_we && (bus_addr == A_SFLAG);
  assign wr_pflag = bus_we && (bus_addr == A_PFLAG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      dir_q  <= '0;
      edge_q <= '0;
      sen_q  <= '0;
      pen_q  <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        A_OUT:  out_q  <= bus_wdata;
        A_DIR:  dir_q  <= bus_wdata;
        A_EDGE: edge_q <= bus_wdata;
        A_SEN:  sen_q  <= bus_wdata[NSPEC-1:0];
        A_PEN:  pen_q  <= bus_wdata[PINS-1:NSPEC];
        default: ;
      endcase
    end
  end

  gpio_sync_edge #(.W(PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(pad_in), .sel_i(edge_q),
    .level_o(level), .event_o(event_w)
  );

  gpio_flag_reg #(.W(NSPEC)) u_sflag (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_sflag),
    .wdata_i(bus_wdata[NSPEC-1:0]), .set_i(event_w[NSPEC-1:0]), .flag_o(sflag)
  );

  gpio_flag_reg #(.W(NPORT)) u_pflag (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_pflag),
    .wdata_i(bus_wdata[PINS-1:NSPEC]), .set_i(event_w[PINS-1:NSPEC]), .flag_o(pflag)
  );

  always_comb begin
    case (bus_addr)
      A_LEVEL: bus_rdata = level;
      A_OUT:   bus_rdata = out_q;
      A_DIR:   bus_rdata = dir_q;
      A_EDGE:  bus_rdata = edge_q;
      A_PFLAG: bus_rdata = {pflag, {NSPEC{1'b0}}};
      A_PEN:   bus_rdata = {pen_q, {NSPEC{1'b0}}};
      A_SFLAG: bus_rdata = {{NPORT{1'b0}}, sflag};
      A_SEN:   bus_rdata = {{NPORT{1'b0}}, sen_q};
      default: bus_rdata = '0;
    endcase
  end

  always_comb begin
    pad_out = out_q;
    if (alt_sel[0]) pad_out[1] = alt_out[0];
    if (alt_sel[1]) pad_out[2] = alt_out[1];
  end
  assign pad_oe = dir_q;

  assign irq_pin0   = sflag[0] & sen_q[0];
  assign irq_pin1   = sflag[1] & sen_q[1];
  assign irq_shared = |(pflag & pen_q);

  // R8: a masked request line stays low
  a_r8_pin0_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !sen_q[0] |-> !irq_pin0);
  a_r8_shared_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (pen_q == '0) |-> !irq_shared);
  // R7: low bits of the port flag register never carry a flag
  a_r7_port_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_PFLAG) |-> (bus_rdata[1:0] == 2'b00));
  // R2: output enable follows the direction register written one cycle earlier
  a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_DIR) |=> (pad_oe == $past(bus_wdata)));
endmodule

// File: tb/test_gpio8_irq_port.sv
module test_gpio8_irq_port;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [2:0] bus_addr = 0;
  logic       bus_we = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic [7:0] pad_in = 0;
  logic [7:0] pad_out, pad_oe;
  logic [1:0] alt_sel = 0, alt_out = 0;
  logic       irq_pin0, irq_pin1, irq_shared;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio8_irq_port i_gpio8_irq_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .alt_sel(alt_sel), .alt_out(alt_out),
    .irq_pin0(irq_pin0), .irq_pin1(irq_pin1), .irq_shared(irq_shared)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_flags();
    wr(3'd4, 8'h00);
    wr(3'd6, 8'h00);
  endtask

  // the flag bit for pin p, from its own register space
  task automatic get_flag(input int p, output logic f);
    logic [7:0] d;
    if (p < 2) rd(3'd6, d); else rd(3'd4, d);
    f = d[p];
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic f;
    wait_clk(2);
    // R1 reset state
    for (int a = 1; a < 8; a++) begin
      rd(a[2:0], d);
      check("R1 reg", d, 8'h00);
    end
    check("R1 oe", pad_oe, 8'h00);
    check("R1 irq", {5'b0, irq_pin0, irq_pin1, irq_shared}, 8'h00);
    rst_n = 1;
    wait_clk(2);

    // R2 direction and output
    wr(3'd1, 8'h3C);
    wr(3'd2, 8'hC3);
    check("R2 out", pad_out, 8'h3C);
    check("R2 oe", pad_oe, 8'hC3);

    // R9 alternate takeover of pins 1 and 2
    alt_sel = 2'b11; alt_out = 2'b01; #1;
    check("R9 alt", pad_out, 8'h3A);
    alt_out = 2'b10; #1;
    check("R9 alt2", pad_out, 8'h3C);
    alt_sel = 2'b00; #1;
    check("R9 release", pad_out, 8'h3C);

    // R3 synchronizer latency
    wr(3'd3, 8'h00);
    pad_in = 8'hA5;
    @(posedge clk); @(negedge clk);
    rd(3'd0, d); check("R3 early", d, 8'h00);
    @(negedge clk);
    rd(3'd0, d); check("R3 ontime", d, 8'hA5);
    pad_in = 8'h00;
    wait_clk(4);
    clear_flags();
    wr(3'd5, 8'h00); wr(3'd7, 8'h00);

    // R4/R5 sweep: every pin, both polarities, both directions, enables off
    for (int p = 0; p < 8; p++) begin
      for (int s = 0; s < 2; s++) begin
        wr(3'd3, 8'(s) << p);
        clear_flags();
        pad_in[p] = 1'b1;
        wait_clk(4);
        get_flag(p, f);
        check($sformatf("R4 R5 rise pin%0d sel%0d", p, s), {7'b0, f}, {7'b0, s == 0});
        check("R8 masked", {5'b0, irq_pin0, irq_pin1, irq_shared}, 8'h00);
        clear_flags();
        pad_in[p] = 1'b0;
        wait_clk(4);
        get_flag(p, f);
        check($sformatf("R4 fall pin%0d sel%0d", p, s), {7'b0, f}, {7'b0, s == 1});
      end
    end

    // R4 exact latency: flag absent after two edges, present after three
    wr(3'd3, 8'h00);
    clear_flags();
    pad_in[3] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    get_flag(3, f); check("R4 latency early", {7'b0, f}, 8'h00);
    @(negedge clk);
    get_flag(3, f); check("R4 latency ontime", {7'b0, f}, 8'h01);
    pad_in[3] = 1'b0;
    wait_clk(4);

    // R7 layout: low bits of the port registers ignore writes and read 0
    wr(3'd4, 8'hFF);
    rd(3'd4, d); check("R7 pflag", d, 8'hFC);
    wr(3'd6, 8'hFF);
    rd(3'd6, d); check("R7 sflag", d, 8'h03);
    wr(3'd5, 8'hFF);
    rd(3'd5, d); check("R7 pen", d, 8'hFC);
    wr(3'd7, 8'hFF);
    rd(3'd7, d); check("R7 sen", d, 8'h03);
    // R6 software write of 1 sets; with all enables, each line high
    check("R8 all", {5'b0, irq_pin0, irq_pin1, irq_shared}, 8'h07);
    clear_flags();
    check("R6 clear", {5'b0, irq_pin0, irq_pin1, irq_shared}, 8'h00);

    // R8 routing per pin via real edges
    for (int p = 0; p < 8; p++) begin
      clear_flags();
      pad_in[p] = 1'b1;
      wait_clk(4);
      check($sformatf("R8 route pin%0d", p),
            {5'b0, irq_pin0, irq_pin1, irq_shared},
            (p == 0) ? 8'h04 : (p == 1) ? 8'h02 : 8'h01);
      pad_in[p] = 1'b0;
      wait_clk(4);
    end
    clear_flags();
    wr(3'd7, 8'h00);
    wr(3'd6, 8'h03);
    check("R8 sfr masked", {5'b0, irq_pin0, irq_pin1, irq_shared}, 8'h00);
    clear_flags();

    // R6 hardware set beats a clearing write in the same cycle
    wr(3'd3, 8'h00);
    for (int p = 0; p < 8; p += 7) begin
      clear_flags();
      pad_in[p] = 1'b1;
      @(posedge clk); @(posedge clk); @(negedge clk);
      bus_addr = (p < 2) ? 3'd6 : 3'd4; bus_wdata = 8'h00; bus_we = 1;
      @(negedge clk);
      bus_we = 0;
      get_flag(p, f);
      check($sformatf("R6 set wins pin%0d", p), {7'b0, f}, 8'h01);
      pad_in[p] = 1'b0;
      wait_clk(4);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule